// File: doc/BRIEF.md
# Transmit Mailbox Priority Selector

This block decides which of three loaded transmit mailboxes is offered next to a CAN transmitter. Software writes an identifier into a free mailbox, which marks that mailbox as pending. Among the pending mailboxes the block names one, together with its identifier, on a valid/index pair. The ordering bit picks one of two rules. In identifier order the lowest identifier goes first. In arrival order the mailbox whose request came first goes first. The choice is local only and has no effect on which frame wins arbitration on the bus.

Once the transmitter takes the offered mailbox, the offer is frozen and later loads or a change of the ordering bit do not alter it. A completion pulse then clears that mailbox's request, which frees it for reloading, and the offer is computed again. Arrival order comes from a small age matrix inside the block, so it holds however long a mailbox waits.

Top module: `tmb_select`

## Requirements
- R1: After synchronous reset no mailbox is pending and `sel_valid` is 0.
- R2: A load (`load_en`=1) to a free mailbox in range makes it pending with `load_id` as its identifier, and this is visible on the outputs right after that clock edge.
- R3: A load to a pending mailbox, or to an index of 3 or more, has no effect on any mailbox.
- R4: With `order_sel`=0 (identifier order), the offered mailbox is the pending one with the numerically lowest identifier, and `sel_id` carries that identifier.
- R5: In identifier order, when pending identifiers are equal, the lowest mailbox index is offered.
- R6: With `order_sel`=1 (arrival order), the offered mailbox is the pending one whose load was accepted earliest. This holds even when other mailboxes have been loaded and freed many times in the meantime.
- R7: `tx_take` while `sel_valid`=1 locks the offer. Until `tx_done`, `sel_idx` and `sel_id` stay fixed whatever is loaded and whatever `order_sel` does.
- R8: `tx_done` while locked clears the locked mailbox's request and releases the lock. The mailbox can be loaded again from the next cycle.
- R9: `tx_done` while not locked, and `tx_take` while `sel_valid`=0, are ignored.
- R10: `sel_valid` is 1 exactly when at least one mailbox is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 1 | Ordering rule: 0 identifier order, 1 arrival order |
| load_en | input | 1 | Load request for one mailbox |
| load_idx | input | 2 | Mailbox index of the load |
| load_id | input | ID_W | Identifier written by the load |
| tx_take | input | 1 | Transmitter accepts the offered mailbox |
| tx_done | input | 1 | Transmitter has finished the accepted mailbox |
| sel_valid | output | 1 | A mailbox is offered |
| sel_idx | output | 2 | Index of the offered mailbox |
| sel_id | output | ID_W | Identifier of the offered mailbox |

## Verification
The bench builds the block with three mailboxes and a 3-bit identifier, which makes the identifier space small enough to sweep completely. Every one of the 512 identifier triples is drained in identifier order, which covers all tie patterns. The same 512 triples are also drained in arrival order under each of the six load orders. Directed sequences add the locked offer, a mailbox that waits while another is reloaded many times, and the ignored loads and pulses.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    typedef enum logic {
        ORDER_BY_ID      = 1'b0,
        ORDER_BY_ARRIVAL = 1'b1
    } order_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tmb_store.sv
module tmb_store #(
    parameter int NUM_MB = 3,
    parameter int ID_W   = 11,
    parameter int IDX_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_en,
    input  logic [IDX_W-1:0]              load_idx,
    input  logic [ID_W-1:0]               load_id,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [NUM_MB-1:0]             pend,
    output logic [NUM_MB-1:0][ID_W-1:0]   ids,
    output logic [NUM_MB-1:0][NUM_MB-1:0] older
);

    logic [NUM_MB-1:0] hit;
    logic [NUM_MB-1:0] clr_hit;

    always_comb begin
        for (int k = 0; k < NUM_MB; k++) begin
            hit[k]     = load_en && (load_idx == IDX_W'(k)) && !pend[k];
            clr_hit[k] = clr_en && (clr_idx == IDX_W'(k));
        end
    end

    // older[k][j] set: mailbox k was loaded before mailbox j
    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            ids   <= '0;
            older <= '0;
        end else begin
            for (int k = 0; k < NUM_MB; k++) begin
                if (hit[k]) begin
                    pend[k] <= 1'b1;
                    ids[k]  <= load_id;
                end else if (clr_hit[k]) begin
                    pend[k] <= 1'b0;
                end
                for (int j = 0; j < NUM_MB; j++) begin
                    if (j != k) begin
                        if (hit[j]) begin
                            older[k][j] <= 1'b1;
                        end else if (hit[k]) begin
                            older[k][j] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_MB; k++) begin : g_chk
        // R2: accepted load makes the mailbox pending with the new identifier
        p_load_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (load_en && load_idx == IDX_W'(k) && !pend[k])
            |=> (pend[k] && ids[k] == $past(load_id)));
        // R3: load to a busy mailbox leaves it alone
        p_busy_load_ignored_r3: assert property (@(posedge clk) disable iff (rst)
            (load_en && load_idx == IDX_W'(k) && pend[k] && !(clr_en && clr_idx == IDX_W'(k)))
            |=> (pend[k] && $stable(ids[k])));
        for (genvar j = k + 1; j < NUM_MB; j++) begin : g_pair
            // R6: any two pending mailboxes have exactly one age relation
            p_age_order_r6: assert property (@(posedge clk) disable iff (rst)
                (pend[k] && pend[j]) |-> (older[k][j] != older[j][k]));
        end
    end

endmodule

// File: rtl/tmb_pick.sv
module tmb_pick
    import tmb_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int ID_W   = 11,
    parameter int IDX_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  order_e                        order,
    input  logic [NUM_MB-1:0]             pend,
    input  logic [NUM_MB-1:0][ID_W-1:0]   ids,
    input  logic [NUM_MB-1:0][NUM_MB-1:0] older,
    output logic                          cand_valid,
    output logic [IDX_W-1:0]              cand_idx
);

    logic [NUM_MB-1:0] win_id;
    logic [NUM_MB-1:0] win_age;
    logic [NUM_MB-1:0] grant;

    always_comb begin
        for (int k = 0; k < NUM_MB; k++) begin
            win_id[k]  = pend[k];
            win_age[k] = pend[k];
            for (int j = 0; j < NUM_MB; j++) begin
                if (j != k && pend[j]) begin
                    if ((ids[j] < ids[k]) || ((ids[j] == ids[k]) && (j < k))) begin
                        win_id[k] = 1'b0;
                    end
                    if (older[j][k]) begin
                        win_age[k] = 1'b0;
                    end
                end
            end
        end
    end

    assign grant = (order == ORDER_BY_ARRIVAL) ? win_age : win_id;

    always_comb begin
        cand_idx = '0;
        for (int k = 0; k < NUM_MB; k++) begin
            if (grant[k]) begin
                cand_idx = IDX_W'(k);
            end
        end
    end

    assign cand_valid = |grant;

    // R4: never more than one winner
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R10: a pending mailbox always yields a winner
    p_grant_when_pending_r10: assert property (@(posedge clk) disable iff (rst)
        (|pend) |-> (|grant));
    // R10: the winner is itself pending
    p_grant_is_pending_r10: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~pend) == '0));

endmodule

// File: rtl/tmb_lock.sv
module tmb_lock #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_valid,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic             take,
    input  logic             done,
    output logic             locked,
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_idx,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    typedef struct packed {
        logic             on;
        logic [IDX_W-1:0] idx;
    } hold_t;

    hold_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (hold_q.on) begin
            if (done) begin
                hold_q.on <= 1'b0;
            end
        end else if (take && cand_valid) begin
            hold_q.on  <= 1'b1;
            hold_q.idx <= cand_idx;
        end
    end

    assign locked    = hold_q.on;
    assign sel_valid = hold_q.on || cand_valid;
    assign sel_idx   = hold_q.on ? hold_q.idx : cand_idx;
    assign clr_en    = hold_q.on && done;
    assign clr_idx   = hold_q.idx;

    // R7: take of a valid offer freezes exactly that offer
    p_take_locks_r7: assert property (@(posedge clk) disable iff (rst)
        (!locked && take && cand_valid) |=> (locked && sel_idx == $past(cand_idx)));
    // R7: offer stays fixed while locked
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && !done) |=> (locked && $stable(sel_idx)));
    // R9: take without an offer does not lock
    p_idle_take_r9: assert property (@(posedge clk) disable iff (rst)
        (!locked && !cand_valid) |=> !locked);

endmodule

// File: rtl/tmb_select.sv
module tmb_select
    import tmb_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int ID_W   = 11,
    localparam int IDX_W = idx_width(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             order_sel,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [ID_W-1:0]  load_id,
    input  logic             tx_take,
    input  logic             tx_done,
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_idx,
    output logic [ID_W-1:0]  sel_id
);

    logic [NUM_MB-1:0]             pend;
    logic [NUM_MB-1:0][ID_W-1:0]   ids;
    logic [NUM_MB-1:0][NUM_MB-1:0] older;
    logic                          cand_valid;
    logic [IDX_W-1:0]              cand_idx;
    logic                          locked;
    logic                          clr_en;
    logic [IDX_W-1:0]              clr_idx;
    order_e                        order;

    assign order = order_e'(order_sel);

    tmb_store #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_idx (load_idx),
        .load_id  (load_id),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .pend     (pend),
        .ids      (ids),
        .older    (older)
    );

    tmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .order      (order),
        .pend       (pend),
        .ids        (ids),
        .older      (older),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx)
    );

    tmb_lock #(.IDX_W(IDX_W)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .take       (tx_take),
        .done       (tx_done),
        .locked     (locked),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );

    always_comb begin
        sel_id = '0;
        for (int k = 0; k < NUM_MB; k++) begin
            if (sel_idx == IDX_W'(k)) begin
                sel_id = ids[k];
            end
        end
    end

    // R8: completion frees the mailbox that was locked
    p_done_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && tx_done) |=> (!locked && ((pend >> $past(sel_idx)) & NUM_MB'(1)) == '0));
    // R1: nothing offered in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !sel_valid);

endmodule

// File: tb/tmb_select_bench.sv
`timescale 1ns/1ps
module tmb_select_bench;

    localparam int NMB  = 3;
    localparam int IDW  = 3;
    localparam int IXW  = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           order_sel;
    logic           load_en;
    logic [IXW-1:0] load_idx;
    logic [IDW-1:0] load_id;
    logic           tx_take;
    logic           tx_done;
    logic           sel_valid;
    logic [IXW-1:0] sel_idx;
    logic [IDW-1:0] sel_id;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmb_select #(.NUM_MB(NMB), .ID_W(IDW)) u_tmb_select (
        .clk       (clk),
        .rst       (rst),
        .order_sel (order_sel),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .load_id   (load_id),
        .tx_take   (tx_take),
        .tx_done   (tx_done),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_id    (sel_id)
    );

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        load_en = 1'b0;
        tx_take = 1'b0;
        tx_done = 1'b0;
    endtask

    task automatic do_load(input int idx, input int id);
        @(negedge clk);
        load_en  = 1'b1;
        load_idx = IXW'(idx);
        load_id  = IDW'(id);
        cyc();
    endtask

    task automatic do_take();
        @(negedge clk);
        tx_take = 1'b1;
        cyc();
    endtask

    task automatic do_done();
        @(negedge clk);
        tx_done = 1'b1;
        cyc();
    endtask

    task automatic drain_one();
        do_take();
        do_done();
    endtask

    function automatic int min_pick(input logic [2:0] pm, input int v0, input int v1, input int v2);
        int vals [3];
        int best;
        vals[0] = v0; vals[1] = v1; vals[2] = v2;
        best = -1;
        for (int k = 0; k < 3; k++) begin
            if (pm[k] && (best < 0 || vals[k] < vals[best])) best = k;
        end
        return best;
    endfunction

    int perm [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int iv [3];
        logic [2:0] pm;
        int e;
        rst = 1'b1; order_sel = 1'b0; load_en = 1'b0; load_idx = '0;
        load_id = '0; tx_take = 1'b0; tx_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(sel_valid, 0, "R1 reset idle");

        // R4 R5: exhaustive identifier-order drain
        order_sel = 1'b0;
        for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) for (int c = 0; c < 8; c++) begin
            iv[0] = a; iv[1] = b; iv[2] = c;
            for (int k = 0; k < 3; k++) do_load(k, iv[k]);
            pm = 3'b111;
            for (int s = 0; s < 3; s++) begin
                e = min_pick(pm, iv[0], iv[1], iv[2]);
                chk(sel_valid, 1, "R10 valid while pending");
                if (a == b || b == c || a == c) chk(sel_idx, e, "R5 tie index");
                else chk(sel_idx, e, "R4 lowest id index");
                chk(sel_id, iv[e], "R4 offered id");
                drain_one();
                pm[e] = 1'b0;
            end
            chk(sel_valid, 0, "R8 drained");
        end

        // R6: exhaustive arrival-order drain under every load order
        order_sel = 1'b1;
        for (int p = 0; p < 6; p++)
        for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) for (int c = 0; c < 8; c++) begin
            iv[0] = a; iv[1] = b; iv[2] = c;
            for (int s = 0; s < 3; s++) do_load(perm[p][s], iv[perm[p][s]]);
            for (int s = 0; s < 3; s++) begin
                chk(sel_idx, perm[p][s], "R6 arrival index");
                chk(sel_id, iv[perm[p][s]], "R6 arrival id");
                drain_one();
            end
            chk(sel_valid, 0, "R10 empty after drain");
        end

        // R6: long wait while another mailbox is recycled
        order_sel = 1'b0;
        do_load(2, 7);
        for (int r = 0; r < 20; r++) begin
            do_load(0, 0);
            chk(sel_idx, 0, "R4 recycled low id");
            drain_one();
        end
        do_load(1, 1);
        do_load(0, 0);
        order_sel = 1'b1;
        #1;
        chk(sel_idx, 2, "R6 oldest after recycling");
        drain_one();
        chk(sel_idx, 1, "R6 second oldest");
        drain_one();
        chk(sel_idx, 0, "R6 newest last");
        drain_one();

        // R6: reload in the middle
        do_load(2, 3);
        do_load(0, 5);
        drain_one();
        do_load(2, 1);
        do_load(1, 0);
        chk(sel_idx, 0, "R6 interleaved first");
        drain_one();
        chk(sel_idx, 2, "R6 interleaved second");
        drain_one();
        chk(sel_idx, 1, "R6 interleaved third");
        drain_one();

        // R7: locked offer ignores loads and mode change
        order_sel = 1'b0;
        do_load(1, 5);
        do_take();
        do_load(0, 0);
        chk(sel_idx, 1, "R7 locked against lower id");
        chk(sel_id, 5, "R7 locked id");
        order_sel = 1'b1;
        #1;
        chk(sel_idx, 1, "R7 locked against mode");
        order_sel = 1'b0;
        do_done();
        chk(sel_idx, 0, "R8 recompute after done");
        // R8: freed mailbox reloadable
        do_load(1, 2);
        do_take();
        do_done();
        chk(sel_idx, 1, "R8 reloaded mailbox offered");
        chk(sel_id, 2, "R8 reloaded id");

        // R3: load to pending and to out-of-range index ignored
        do_load(1, 0);
        chk(sel_id, 2, "R3 busy load ignored");
        do_load(3, 0);
        chk(sel_idx, 1, "R3 out of range ignored");
        drain_one();
        chk(sel_valid, 0, "R3 no phantom mailbox");

        // R9: stray done and idle take
        do_load(2, 6);
        do_done();
        chk(sel_valid, 1, "R9 stray done keeps request");
        chk(sel_idx, 2, "R9 stray done index");
        drain_one();
        do_take();
        do_load(2, 4);
        do_load(0, 1);
        chk(sel_idx, 0, "R9 idle take not locked");
        drain_one();
        drain_one();
        chk(sel_valid, 0, "R10 final empty");

        // R1: reset with pending mailboxes
        do_load(0, 3);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk(sel_valid, 0, "R1 reset clears pending");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule